// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Scheduled Block Refill

This block is a read-only, direct-mapped cache between a processor read port and a plain memory bus, with word addressing. The processor raises a request with a word address and holds it until the cache answers. If the addressed block is present, the 32-bit word comes back combinationally in the same cycle. If it is absent, the processor is stalled while the cache fetches the whole aligned block on a cycle-exact bus schedule. Only after the last beat has arrived does the processor get its word.

A miss is detected in the cycle of the request. The cycle after that drives the block address on the bus for one cycle. A fixed memory wait follows, lengthened by an optional contention allowance. Then one data beat arrives per cycle, each carrying one or four words depending on the bus-width parameter. Words are written into the data array as they land. The tag and valid bit are installed on the final beat. The requested word is forwarded in that same cycle, so a default miss costs 1 + 1 + 4 + B cycles. Hit, miss and stall-cycle counters let a bench confirm that the average access time is 1 + m(5 + B) cycles.

The memory side is a fixed-timing responder. The cache samples the bus data lines in each transfer cycle, and nothing on the bus acknowledges a beat.

Top module: `blk_refill_cache`

## Requirements
- R1: After reset, every line is invalid, all three counters read zero, and `stall`, `rsp_valid` and `bus_addr_valid` are low. The first access to any address is therefore a miss.
- R2: A request whose block is present gets `rsp_valid` high in the request cycle, with `stall` low and `rsp_data` equal to the stored word.
- R3: On a miss, `stall` is high in the request cycle. `bus_addr_valid` is high for exactly one cycle, in the next cycle, carrying the requested word address with its low OFFSET_W bits forced to zero.
- R4: After the address cycle, MEM_LATENCY (4) + CONTENTION cycles pass with `stall` high before the first data beat is sampled.
- R5: Beats are sampled on consecutive cycles in ascending order. In beat j, bits [32k+31:32k] of `bus_data` hold block word j*BUS_WORDS+k.
- R6: `stall` stays high through every beat but the last. The response comes in the final beat's cycle with `stall` low and the requested word, wherever it sits in the block. A miss therefore lasts 6 + CONTENTION + BEATS cycles, which is 1+1+4+B by default.
- R7: Once a refill completes, the block's tag and valid bit are installed, and every word of that block hits.
- R8: A request to the same index with a different tag misses and replaces the line. A return to the evicted block then misses again.
- R9: `hit_count` and `miss_count` count completed lookups. `stall_count` counts stalled cycles, and each miss adds 5 + CONTENTION + BEATS. Total access cycles therefore equal N + misses*(5 + CONTENTION + BEATS).
- R10: With BUS_WORDS = 4, BEATS = max(1, block words / 4). A 16-word block refills in 4 beats, and a 2-word block still uses one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor read request, held until answered |
| req_addr | input | ADDR_W | Requested word address (tag, index, offset from MSB down) |
| rsp_valid | output | 1 | Requested word is on `rsp_data` this cycle |
| rsp_data | output | WORD_W | Returned word |
| stall | output | 1 | Processor must hold its request |
| bus_addr_valid | output | 1 | Block-address cycle of a refill |
| bus_addr | output | ADDR_W | Block-aligned word address of the refill |
| bus_data | input | BUS_WORDS*WORD_W | Refill beat data, lane k holds word k of the beat |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |
| stall_count | output | CNT_W | Number of stalled cycles |

## Verification
Directed accesses are used first. A cold miss is followed by a repeat hit and by hits at the first and last word of the filled block, which separates the array read path from the final-beat forward path. A same-index, different-tag pair shows eviction, as opposed to a stale hit. Random addresses drawn from a small tag and index pool then force frequent conflicts and idle gaps between requests. The same sequences run on a narrow bus, on a wide bus with contention, and on a wide bus with a two-word block. Comparing these three tells the per-beat lane mapping and the minimum-one-beat rule apart from the plain word-by-word refill, and confirms that contention adds to the wait phase only.

// File: rtl/blk_cache_pkg.sv
package blk_cache_pkg;

   typedef enum logic [1:0] {
      FILL_IDLE = 2'd0,
      FILL_ADDR = 2'd1,
      FILL_WAIT = 2'd2,
      FILL_XFER = 2'd3
   } fill_state_e;

   // number of bus beats needed to move one block; never below one
   function automatic int unsigned beats_per_block(int unsigned block_words,
                                                   int unsigned bus_words);
      return (block_words > bus_words) ? block_words / bus_words : 1;
   endfunction

   // counter width able to index n distinct values; at least one bit
   function automatic int unsigned cnt_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/blk_cache_refill_fsm.sv
module blk_cache_refill_fsm
   import blk_cache_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned WAIT_CYC = 4,
   parameter int unsigned BEATS    = 16,
   parameter int unsigned BEAT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_i,
   input  logic [ADDR_W-1:0] miss_addr_i,
   output fill_state_e       state_o,
   output logic [BEAT_W-1:0] beat_o,
   output logic              last_beat_o,
   output logic [ADDR_W-1:0] held_addr_o
);

   localparam int unsigned WAIT_W = cnt_width(WAIT_CYC);

   fill_state_e       state_q;
   logic [WAIT_W-1:0] wait_q;
   logic [BEAT_W-1:0] beat_q;
   logic [ADDR_W-1:0] addr_q;

   assign state_o     = state_q;
   assign beat_o      = beat_q;
   assign held_addr_o = addr_q;
   assign last_beat_o = (state_q == FILL_XFER) && (beat_q == BEAT_W'(BEATS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FILL_IDLE;
         wait_q  <= '0;
         beat_q  <= '0;
         addr_q  <= '0;
      end else begin
         case (state_q)
            FILL_IDLE: begin
               if (miss_i) begin
                  addr_q  <= miss_addr_i;
                  state_q <= FILL_ADDR;
               end
            end
            FILL_ADDR: begin
               wait_q  <= '0;
               state_q <= FILL_WAIT;
            end
            FILL_WAIT: begin
               if (wait_q == WAIT_W'(WAIT_CYC - 1)) begin
                  beat_q  <= '0;
                  state_q <= FILL_XFER;
               end else begin
                  wait_q <= wait_q + WAIT_W'(1);
               end
            end
            FILL_XFER: begin
               if (last_beat_o) begin
                  state_q <= FILL_IDLE;
               end else begin
                  beat_q <= beat_q + BEAT_W'(1);
               end
            end
            default: state_q <= FILL_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/blk_cache_tag_store.sv
module blk_cache_tag_store #(
   parameter int unsigned INDEX_W = 6,
   parameter int unsigned TAG_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] look_index_i,
   input  logic [TAG_W-1:0]   look_tag_i,
   output logic               hit_o,
   input  logic               install_i,
   input  logic [INDEX_W-1:0] inst_index_i,
   input  logic [TAG_W-1:0]   inst_tag_i
);

   localparam int unsigned LINES = 1 << INDEX_W;

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (install_i) begin
         valid_q[inst_index_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (install_i) begin
         tag_q[inst_index_i] <= inst_tag_i;
      end
   end

   assign hit_o = valid_q[look_index_i] && (tag_q[look_index_i] == look_tag_i);

endmodule

// File: rtl/blk_cache_data_store.sv
module blk_cache_data_store #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned INDEX_W   = 6,
   parameter int unsigned OFFSET_W  = 4,
   parameter int unsigned BUS_WORDS = 1,
   parameter int unsigned BEATS     = 16,
   parameter int unsigned BEAT_W    = 4
) (
   input  logic                          clk,
   input  logic                          wr_en_i,
   input  logic [INDEX_W-1:0]            wr_index_i,
   input  logic [BEAT_W-1:0]             wr_beat_i,
   input  logic [BUS_WORDS*WORD_W-1:0]   wr_data_i,
   input  logic [INDEX_W-1:0]            rd_index_i,
   input  logic [OFFSET_W-1:0]           rd_off_i,
   output logic [WORD_W-1:0]             rd_data_o
);

   localparam int unsigned BLOCK_WORDS = 1 << OFFSET_W;
   localparam int unsigned LANES       = (BUS_WORDS < BLOCK_WORDS) ? BUS_WORDS : BLOCK_WORDS;
   localparam int unsigned LANE_SH     = (BUS_WORDS > 1) ? $clog2(BUS_WORDS) : 0;
   localparam int unsigned DEPTH       = (1 << INDEX_W) * BLOCK_WORDS;

   logic [WORD_W-1:0]   mem_q [DEPTH];
   logic [OFFSET_W-1:0] lane_off [LANES];

   // word offset written by each bus lane in the current beat
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (BEATS == 1) begin : g_single
         assign lane_off[k] = OFFSET_W'(k);
      end else if (BUS_WORDS == 1) begin : g_narrow
         assign lane_off[k] = wr_beat_i;
      end else begin : g_wide
         assign lane_off[k] = {wr_beat_i, LANE_SH'(k)};
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         for (int k = 0; k < LANES; k++) begin
            mem_q[{wr_index_i, lane_off[k]}] <= wr_data_i[k*WORD_W +: WORD_W];
         end
      end
   end

   assign rd_data_o = mem_q[{rd_index_i, rd_off_i}];

endmodule

// File: rtl/blk_cache_perf_cnt.sv
module blk_cache_perf_cnt #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             miss_i,
   input  logic             stall_i,
   output logic [CNT_W-1:0] hits_o,
   output logic [CNT_W-1:0] misses_o,
   output logic [CNT_W-1:0] stalls_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hits_o   <= '0;
         misses_o <= '0;
         stalls_o <= '0;
      end else begin
         if (hit_i)   hits_o   <= hits_o   + CNT_W'(1);
         if (miss_i)  misses_o <= misses_o + CNT_W'(1);
         if (stall_i) stalls_o <= stalls_o + CNT_W'(1);
      end
   end

endmodule

// File: rtl/blk_refill_cache.sv
module blk_refill_cache
   import blk_cache_pkg::*;
#(
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned ADDR_W      = 17,
   parameter int unsigned INDEX_W     = 6,
   parameter int unsigned OFFSET_W    = 4,
   parameter int unsigned BUS_WORDS   = 1,
   parameter int unsigned MEM_LATENCY = 4,
   parameter int unsigned CONTENTION  = 0,
   parameter int unsigned CNT_W       = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [ADDR_W-1:0]           req_addr,
   output logic                        rsp_valid,
   output logic [WORD_W-1:0]           rsp_data,
   output logic                        stall,
   output logic                        bus_addr_valid,
   output logic [ADDR_W-1:0]           bus_addr,
   input  logic [BUS_WORDS*WORD_W-1:0] bus_data,
   output logic [CNT_W-1:0]            hit_count,
   output logic [CNT_W-1:0]            miss_count,
   output logic [CNT_W-1:0]            stall_count
);

   localparam int unsigned TAG_W       = ADDR_W - INDEX_W - OFFSET_W;
   localparam int unsigned BLOCK_WORDS = 1 << OFFSET_W;
   localparam int unsigned BEATS       = beats_per_block(BLOCK_WORDS, BUS_WORDS);
   localparam int unsigned BEAT_W      = cnt_width(BEATS);
   localparam int unsigned WAIT_CYC    = MEM_LATENCY + CONTENTION;

   // elaboration-time parameter checks
   if (ADDR_W <= INDEX_W + OFFSET_W) begin : g_bad_tag
      $error("address too narrow for index and offset");
   end
   if (OFFSET_W < 1) begin : g_bad_block
      $error("block must hold at least two words");
   end
   if ((BUS_WORDS == 0) || ((BUS_WORDS & (BUS_WORDS - 1)) != 0)) begin : g_bad_bus
      $error("bus word count must be a power of two");
   end
   if (MEM_LATENCY < 1) begin : g_bad_lat
      $error("memory latency must be at least one cycle");
   end

   fill_state_e         fill_state;
   logic [BEAT_W-1:0]   fill_beat;
   logic                last_beat;
   logic [ADDR_W-1:0]   held_addr;
   logic                lookup_hit;
   logic                idle;
   logic                hit_now;
   logic                miss_now;
   logic [WORD_W-1:0]   array_word;
   logic [WORD_W-1:0]   fwd_word;
   logic                fwd_from_bus;
   int unsigned         fwd_beat;
   int unsigned         fwd_lane;

   wire [TAG_W-1:0]    req_tag    = req_addr[ADDR_W-1 -: TAG_W];
   wire [INDEX_W-1:0]  req_index  = req_addr[OFFSET_W +: INDEX_W];
   wire [OFFSET_W-1:0] req_off    = req_addr[OFFSET_W-1:0];
   wire [TAG_W-1:0]    held_tag   = held_addr[ADDR_W-1 -: TAG_W];
   wire [INDEX_W-1:0]  held_index = held_addr[OFFSET_W +: INDEX_W];
   wire [OFFSET_W-1:0] held_off   = held_addr[OFFSET_W-1:0];

   assign idle     = (fill_state == FILL_IDLE);
   assign hit_now  = idle && req_valid && lookup_hit;
   assign miss_now = idle && req_valid && !lookup_hit;

   blk_cache_refill_fsm #(
      .ADDR_W   (ADDR_W),
      .WAIT_CYC (WAIT_CYC),
      .BEATS    (BEATS),
      .BEAT_W   (BEAT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss_i      (miss_now),
      .miss_addr_i (req_addr),
      .state_o     (fill_state),
      .beat_o      (fill_beat),
      .last_beat_o (last_beat),
      .held_addr_o (held_addr)
   );

   blk_cache_tag_store #(
      .INDEX_W (INDEX_W),
      .TAG_W   (TAG_W)
   ) u_tags (
      .clk          (clk),
      .rst_n        (rst_n),
      .look_index_i (req_index),
      .look_tag_i   (req_tag),
      .hit_o        (lookup_hit),
      .install_i    (last_beat),
      .inst_index_i (held_index),
      .inst_tag_i   (held_tag)
   );

   blk_cache_data_store #(
      .WORD_W    (WORD_W),
      .INDEX_W   (INDEX_W),
      .OFFSET_W  (OFFSET_W),
      .BUS_WORDS (BUS_WORDS),
      .BEATS     (BEATS),
      .BEAT_W    (BEAT_W)
   ) u_data (
      .clk        (clk),
      .wr_en_i    (fill_state == FILL_XFER),
      .wr_index_i (held_index),
      .wr_beat_i  (fill_beat),
      .wr_data_i  (bus_data),
      .rd_index_i (idle ? req_index : held_index),
      .rd_off_i   (idle ? req_off : held_off),
      .rd_data_o  (array_word)
   );

   blk_cache_perf_cnt #(
      .CNT_W (CNT_W)
   ) u_perf (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_i    (hit_now),
      .miss_i   (miss_now),
      .stall_i  (stall),
      .hits_o   (hit_count),
      .misses_o (miss_count),
      .stalls_o (stall_count)
   );

   // the requested word comes from the final beat itself or from an earlier one
   always_comb begin
      fwd_beat     = 32'(held_off) / BUS_WORDS;
      fwd_lane     = 32'(held_off) % BUS_WORDS;
      fwd_from_bus = (fwd_beat >= BEATS - 1);
      fwd_word     = bus_data[fwd_lane*WORD_W +: WORD_W];
   end

   assign rsp_valid = hit_now || last_beat;
   assign rsp_data  = (last_beat && fwd_from_bus) ? fwd_word : array_word;

   assign stall = miss_now
               || (fill_state == FILL_ADDR)
               || (fill_state == FILL_WAIT)
               || ((fill_state == FILL_XFER) && !last_beat);

   assign bus_addr_valid = (fill_state == FILL_ADDR);
   assign bus_addr       = {held_addr[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};

endmodule

// File: rtl/blk_refill_cache_chk.sv
module blk_refill_cache_chk
   import blk_cache_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned OFFSET_W = 4,
   parameter int unsigned CNT_W    = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              lookup_hit,
   input fill_state_e       fill_state,
   input logic              stall,
   input logic              rsp_valid,
   input logic              bus_addr_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  miss_count,
   input logic [CNT_W-1:0]  stall_count
);

   p_hit_unstalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !stall);

   p_miss_then_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_state == FILL_IDLE && req_valid && !lookup_hit) |=> bus_addr_valid);

   p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_valid |-> (bus_addr[OFFSET_W-1:0] == '0));

   p_addr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_valid |=> (!bus_addr_valid && stall));

   p_release_with_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> rsp_valid);

   p_miss_counted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_valid |-> (miss_count == $past(miss_count) + CNT_W'(1)));

   p_stall_counted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (stall_count == $past(stall_count) + CNT_W'(1)));

endmodule

bind blk_refill_cache blk_refill_cache_chk #(
   .ADDR_W   (ADDR_W),
   .OFFSET_W (OFFSET_W),
   .CNT_W    (CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .lookup_hit     (lookup_hit),
   .fill_state     (fill_state),
   .stall          (stall),
   .rsp_valid      (rsp_valid),
   .bus_addr_valid (bus_addr_valid),
   .bus_addr       (bus_addr),
   .miss_count     (miss_count),
   .stall_count    (stall_count)
);

// File: tb/blk_refill_cache_lane.sv
module blk_refill_cache_lane #(
   parameter int unsigned LANE       = 0,
   parameter int unsigned BUS_WORDS  = 1,
   parameter int unsigned CONTENTION = 0,
   parameter int unsigned OFFSET_W   = 4,
   parameter int unsigned SEED       = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   checks,
   output int   fails
);

   localparam int unsigned ADDR_W     = 17;
   localparam int unsigned INDEX_W    = 6;
   localparam int unsigned TAG_W      = ADDR_W - INDEX_W - OFFSET_W;
   localparam int unsigned BLK        = 1 << OFFSET_W;
   localparam int unsigned BEATS_E    = (BLK > BUS_WORDS) ? BLK / BUS_WORDS : 1;
   localparam int unsigned WAIT_E     = 4 + CONTENTION;
   localparam int unsigned MISS_STALL = 5 + CONTENTION + BEATS_E;

   logic                    req_valid;
   logic [ADDR_W-1:0]       req_addr;
   logic                    rsp_valid;
   logic [31:0]             rsp_data;
   logic                    stall;
   logic                    bus_addr_valid;
   logic [ADDR_W-1:0]       bus_addr;
   logic [BUS_WORDS*32-1:0] bus_data;
   logic [31:0]             hit_count;
   logic [31:0]             miss_count;
   logic [31:0]             stall_count;

   blk_refill_cache #(
      .WORD_W      (32),
      .ADDR_W      (ADDR_W),
      .INDEX_W     (INDEX_W),
      .OFFSET_W    (OFFSET_W),
      .BUS_WORDS   (BUS_WORDS),
      .MEM_LATENCY (4),
      .CONTENTION  (CONTENTION),
      .CNT_W       (32)
   ) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_addr       (req_addr),
      .rsp_valid      (rsp_valid),
      .rsp_data       (rsp_data),
      .stall          (stall),
      .bus_addr_valid (bus_addr_valid),
      .bus_addr       (bus_addr),
      .bus_data       (bus_data),
      .hit_count      (hit_count),
      .miss_count     (miss_count),
      .stall_count    (stall_count)
   );

   bit              ref_valid [1 << INDEX_W];
   logic [TAG_W-1:0] ref_tag  [1 << INDEX_W];
   int unsigned     n_acc, n_hit, n_miss;
   longint unsigned n_cycles;
   int unsigned     last_lat;

   function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a);
      return ({15'h0, a} * 32'h9E3779B1) ^ 32'hC3A5_0000 ^ 32'(SEED);
   endfunction

   function automatic logic [ADDR_W-1:0] mk(input int unsigned t, input int unsigned i,
                                           input int unsigned o);
      return ADDR_W'((t << (INDEX_W + OFFSET_W)) | (i << OFFSET_W) | o);
   endfunction

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s lane %0d: actual %0h expected %0h", rq, LANE, act, exp);
      end
   endtask

   // behavioural memory: fixed schedule after each address cycle
   initial begin
      bus_data = '1;
      forever begin
         @(negedge clk);
         if (bus_addr_valid) begin
            logic [ADDR_W-1:0] base;
            base = bus_addr;
            repeat (WAIT_E + 1) @(negedge clk);
            for (int j = 0; j < BEATS_E; j++) begin
               for (int k = 0; k < BUS_WORDS; k++) begin
                  bus_data[k*32 +: 32] = mem_word(ADDR_W'(32'(base) + j*BUS_WORDS + k));
               end
               @(negedge clk);
               bus_data = '1;
            end
         end
      end
   end

   task automatic access(input logic [ADDR_W-1:0] a);
      int unsigned idx  = 32'(a[OFFSET_W +: INDEX_W]);
      logic [TAG_W-1:0] tg = a[ADDR_W-1 -: TAG_W];
      bit exp_hit = ref_valid[idx] && (ref_tag[idx] == tg);
      logic [ADDR_W-1:0] blk = {a[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};
      int unsigned cyc = 0;
      bit bad_stall = 0;
      bit bad_bus = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      while (cyc < 200) begin
         #1;
         if (rsp_valid) break;
         if (!stall) bad_stall = 1;
         if (bus_addr_valid != (cyc == 1)) bad_bus = 1;
         if (bus_addr_valid && bus_addr != blk) bad_bus = 1;
         @(negedge clk);
         cyc++;
      end
      if (stall || bus_addr_valid) bad_stall = 1;
      chk(rsp_data == mem_word(a), exp_hit ? "R2" : "R5", rsp_data, mem_word(a));
      if (exp_hit) begin
         chk(cyc == 0, "R2", cyc, 0);
      end else begin
         chk(cyc == MISS_STALL, (BUS_WORDS > 1) ? "R10" : "R6", cyc, MISS_STALL);
         chk(!bad_bus, "R3", bad_bus, 0);
         chk(!bad_stall, "R4", bad_stall, 0);
      end
      last_lat = cyc;
      n_acc++;
      n_cycles += cyc + 1;
      if (exp_hit) n_hit++; else n_miss++;
      ref_valid[idx] = 1'b1;
      ref_tag[idx]   = tg;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ADDR_W'($urandom);
   endtask

   initial begin
      done = 0; checks = 0; fails = 0;
      n_acc = 0; n_hit = 0; n_miss = 0; n_cycles = 0; last_lat = 0;
      req_valid = 1'b0;
      req_addr  = '0;
      for (int i = 0; i < (1 << INDEX_W); i++) begin
         ref_valid[i] = 1'b0;
         ref_tag[i]   = '0;
      end
      void'($urandom(SEED));
      @(posedge rst_n);
      @(negedge clk);
      #1;
      // R1 reset state
      chk(!stall && !rsp_valid && !bus_addr_valid, "R1", {stall, rsp_valid, bus_addr_valid}, 0);
      chk(hit_count == 0 && miss_count == 0 && stall_count == 0, "R1",
          hit_count + miss_count + stall_count, 0);

      // directed corners
      access(mk(3, 5, 7 % BLK));
      chk(last_lat == MISS_STALL, "R1", last_lat, MISS_STALL);
      access(mk(3, 5, 7 % BLK));
      access(mk(3, 5, 0));
      chk(last_lat == 0, "R7", last_lat, 0);
      access(mk(3, 5, BLK - 1));
      chk(last_lat == 0, "R7", last_lat, 0);
      access(mk(1, 9, BLK - 1));
      access(mk(1, 9, 0));
      access(mk(2, 5, 3 % BLK));
      chk(last_lat == MISS_STALL, "R8", last_lat, MISS_STALL);
      access(mk(3, 5, 7 % BLK));
      chk(last_lat == MISS_STALL, "R8", last_lat, MISS_STALL);
      access(mk((1 << TAG_W) - 1, (1 << INDEX_W) - 1, 0));
      idle_cycle();
      access(mk((1 << TAG_W) - 1, (1 << INDEX_W) - 1, BLK - 1));

      // constrained random: small pool of tags and indices forces conflicts
      for (int n = 0; n < 250; n++) begin
         if ($urandom % 8 == 0) idle_cycle();
         access(mk($urandom % 4, $urandom % 8, $urandom % BLK));
      end

      idle_cycle();
      #1;
      chk(hit_count == n_hit, "R9", hit_count, n_hit);
      chk(miss_count == n_miss, "R9", miss_count, n_miss);
      chk(stall_count == n_miss * MISS_STALL, "R9", stall_count, n_miss * MISS_STALL);
      chk(n_cycles == n_acc + longint'(n_miss) * MISS_STALL, "R9", n_cycles,
          n_acc + longint'(n_miss) * MISS_STALL);
      done = 1;
   end

endmodule

// File: tb/blk_refill_cache_tb_top.sv
module blk_refill_cache_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic d0, d1, d2;
   int   c0, c1, c2, f0, f1, f2;
   int   waited = 0;
   int   total_checks, total_fails;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // narrow bus, no contention
   blk_refill_cache_lane #(.LANE(0), .BUS_WORDS(1), .CONTENTION(0), .OFFSET_W(4), .SEED(11))
      u_lane0 (.clk(clk), .rst_n(rst_n), .done(d0), .checks(c0), .fails(f0));
   // wide bus with contention (R10, R4)
   blk_refill_cache_lane #(.LANE(1), .BUS_WORDS(4), .CONTENTION(3), .OFFSET_W(4), .SEED(23))
      u_lane1 (.clk(clk), .rst_n(rst_n), .done(d1), .checks(c1), .fails(f1));
   // wide bus, two-word block: one beat minimum (R10)
   blk_refill_cache_lane #(.LANE(2), .BUS_WORDS(4), .CONTENTION(0), .OFFSET_W(1), .SEED(37))
      u_lane2 (.clk(clk), .rst_n(rst_n), .done(d2), .checks(c2), .fails(f2));

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   end

   initial begin
      while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && waited < WATCHDOG) begin
         @(posedge clk);
         waited++;
      end
      total_checks = c0 + c1 + c2;
      total_fails  = f0 + f1 + f2;
      if (waited >= WATCHDOG) begin
         total_checks++;
         total_fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", waited);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", total_checks, total_fails);
      $finish;
   end

endmodule